// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the primary status flags of a two-wire serial interface that can act as bus master or slave. A separate bus engine does the bit shifting and arbitration; it reports what happened through single-cycle event strobes (start requested, start generated, stop seen, arbitration lost, own address matched, address acknowledged, byte sent, byte received). From those strobes the block keeps four flags: start generated, master mode, address matched and byte transfer finished.

Software clears the flags with accesses on the status and data registers. The block sees those accesses as read and write strobes. Address-matched clears on a status read alone. Start-generated and byte-finished need two steps: a status read in an earlier cycle, then a particular data register access. The block asks the bus engine to hold the clock line low while an address match or a finished byte is pending. It also drives one interrupt line, gated by an enable input.

Clearing the peripheral enable wipes every flag at once. The reset input is asynchronous and active low. Its release is synchronised inside the block, so flags can change from the third clock edge after release.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset the status word reads zero. Field positions are: bit 0 start-generated, bit 1 master mode, bit 2 address matched, bit 3 byte finished. Bits 7..4 always read 0.
- R2: Start-generated (bit 0) sets on the clock edge that samples `ev_start_gen_i`. It clears only on a `data_wr_i` that comes after a `stat_rd_i` seen in an earlier cycle while the flag was 1. A data write with no such prior read leaves it set.
- R3: Master mode (bit 1) sets on `ev_start_req_i` and clears on `ev_stop_i` or `ev_arb_lost_i`. It raises no interrupt.
- R4: Address matched (bit 2) sets on `ev_addr_match_i` and clears on a single `stat_rd_i` sampled while it is 1.
- R5: Byte finished (bit 3) sets on `ev_tx_done_i` or `ev_addr_ack_i`. After such a set, only a status read followed by `data_wr_i` clears it; `data_rd_i` leaves it set.
- R6: `ev_rx_done_i` sets byte finished only when `ack_en_i` is 1. After such a set, only a status read followed by `data_rd_i` clears it; `data_wr_i` leaves it set.
- R7: While `periph_en_i` is 0, all four flags are 0 from the next edge on, and set events are ignored.
- R8: A set event wins over a clearing access in the same cycle. A set event also discards any pending first step, so a new status read is needed.
- R9: A status read taken while a two-step flag is 0 arms nothing. The armed step is dropped whenever the flag clears.
- R10: `scl_hold_o` is 1 exactly when address matched or byte finished is 1.
- R11: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one of start-generated, address matched or byte finished is 1.
- R12: A status read in the same cycle as the data access does not count as the first step of a two-step clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en_i | input | 1 | Peripheral enable; 0 wipes all flags |
| irq_en_i | input | 1 | Interrupt enable |
| ack_en_i | input | 1 | Acknowledge enable for received bytes |
| ev_start_req_i | input | 1 | Software wrote the start request |
| ev_start_gen_i | input | 1 | Start condition generated on the bus |
| ev_stop_i | input | 1 | Stop condition detected |
| ev_arb_lost_i | input | 1 | Arbitration lost |
| ev_addr_match_i | input | 1 | Own address or general call received |
| ev_addr_ack_i | input | 1 | Sent address byte acknowledged |
| ev_tx_done_i | input | 1 | Data byte sent and acknowledge clock received |
| ev_rx_done_i | input | 1 | Data byte received and acknowledge clock sent |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| status_o | output | STAT_W | Status word |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Request to hold the clock line low |

## Verification
The hardest cases to reach from the ports are the ones where the armed first step lives across cycles and then meets something else in the same cycle as the second step. Examples are a new byte event landing exactly on the clearing write, a status read issued while the flag was still clear, and a data access of the wrong direction after a received byte. Directed sequences build each of these one cycle at a time. A long random phase follows, with sparse strobes and rare enable drops, compared every cycle against a behavioural model. That phase reaches the remaining mixtures of read, access and event.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;
  localparam int SB_POS   = 0;
  localparam int MSL_POS  = 1;
  localparam int ADSL_POS = 2;
  localparam int BTF_POS  = 3;
  localparam int NFLAG    = 4;

  typedef struct packed {
    logic btf;
    logic adsl;
    logic msl;
    logic sb;
  } sf_flags_t;
endpackage

// File: rtl/sf_rst_sync.sv
module sf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sf_flag_cell.sv
module sf_flag_cell #(
  parameter bit TWO_STEP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic clear_hit;

  generate
    if (TWO_STEP) begin : g_two
      assign clear_hit = flag_q & armed_q & clr_i;
      always_comb begin
        armed_d = flag_d & ~set_i & ~kill_i & (armed_q | (rd_i & flag_q));
      end
    end else begin : g_one
      assign clear_hit = flag_q & clr_i;
      always_comb begin
        armed_d = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (kill_i)         flag_d = 1'b0;
    else if (set_i)     flag_d = 1'b1;
    else if (clear_hit) flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && set_i) |=> flag_q) else $error("set lost"); // R8
  AST_KILL_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (!flag_q && !armed_q)) else $error("kill ignored"); // R7
  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> flag_q) else $error("stale arm"); // R9

  generate
    if (TWO_STEP) begin : g_chk
      AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !kill_i && !armed_q) |=> flag_q) else $error("cleared without first step"); // R12
      AST_SET_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !armed_q) else $error("arm survived set"); // R8
    end
  endgenerate
endmodule

// File: rtl/sf_btf_track.sv
module sf_btf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic tx_i,
  input  logic addr_ack_i,
  input  logic rx_i,
  input  logic ack_en_i,
  input  logic data_rd_i,
  input  logic data_wr_i,
  output logic set_o,
  output logic acc_o
);
  logic rx_set;
  logic dir_q, dir_d, dir_en;

  assign rx_set = rx_i & ack_en_i;
  assign set_o  = tx_i | addr_ack_i | rx_set;

  always_comb begin
    dir_en = set_o & ~kill_i;
    dir_d  = rx_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= dir_d;
  end

  assign acc_o = dir_q ? data_rd_i : data_wr_i;

  AST_RX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && rx_set) |=> dir_q) else $error("rx direction lost"); // R6
  AST_TX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && (tx_i || addr_ack_i) && !rx_set) |=> !dir_q) else $error("tx direction lost"); // R5
endmodule

// File: rtl/sf_irq_out.sv
module sf_irq_out
  import i2c_sf_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  sf_flags_t          flags_i,
  input  logic               irq_en_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               irq_o,
  output logic               scl_hold_o
);
  localparam int PAD_W = STAT_W - NFLAG;

  always_comb begin
    status_o           = '0;
    status_o[SB_POS]   = flags_i.sb;
    status_o[MSL_POS]  = flags_i.msl;
    status_o[ADSL_POS] = flags_i.adsl;
    status_o[BTF_POS]  = flags_i.btf;
  end

  assign scl_hold_o = flags_i.adsl | flags_i.btf;
  assign irq_o      = irq_en_i & (flags_i.sb | flags_i.adsl | flags_i.btf);

  always_comb begin
    AST_PAD_ZERO: assert (PAD_W <= 0 || status_o[STAT_W-1:NFLAG] == '0) else $error("pad bits"); // R1
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_sf_pkg::*;
#(
  parameter int STAT_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en_i,
  input  logic              irq_en_i,
  input  logic              ack_en_i,
  input  logic              ev_start_req_i,
  input  logic              ev_start_gen_i,
  input  logic              ev_stop_i,
  input  logic              ev_arb_lost_i,
  input  logic              ev_addr_match_i,
  input  logic              ev_addr_ack_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_rx_done_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              scl_hold_o
);
  logic      rst_sync_n;
  logic      kill;
  logic      btf_set, btf_acc;
  logic      sb_armed, msl_armed, adsl_armed, btf_armed;
  sf_flags_t flags;

  assign kill = ~periph_en_i;

  sf_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sf_flag_cell #(.TWO_STEP(1'b1)) u_sb (
    .clk(clk), .rst_n(rst_sync_n), .kill_i(kill), .set_i(ev_start_gen_i),
    .rd_i(stat_rd_i), .clr_i(data_wr_i), .flag_o(flags.sb), .armed_o(sb_armed)
  );

  sf_flag_cell #(.TWO_STEP(1'b0)) u_msl (
    .clk(clk), .rst_n(rst_sync_n), .kill_i(kill), .set_i(ev_start_req_i),
    .rd_i(stat_rd_i), .clr_i(ev_stop_i | ev_arb_lost_i), .flag_o(flags.msl),
    .armed_o(msl_armed)
  );

  sf_flag_cell #(.TWO_STEP(1'b0)) u_adsl (
    .clk(clk), .rst_n(rst_sync_n), .kill_i(kill), .set_i(ev_addr_match_i),
    .rd_i(stat_rd_i), .clr_i(stat_rd_i), .flag_o(flags.adsl),
    .armed_o(adsl_armed)
  );

  sf_btf_track u_btrk (
    .clk(clk), .rst_n(rst_sync_n), .kill_i(kill), .tx_i(ev_tx_done_i),
    .addr_ack_i(ev_addr_ack_i), .rx_i(ev_rx_done_i), .ack_en_i(ack_en_i),
    .data_rd_i(data_rd_i), .data_wr_i(data_wr_i), .set_o(btf_set), .acc_o(btf_acc)
  );

  sf_flag_cell #(.TWO_STEP(1'b1)) u_btf (
    .clk(clk), .rst_n(rst_sync_n), .kill_i(kill), .set_i(btf_set),
    .rd_i(stat_rd_i), .clr_i(btf_acc), .flag_o(flags.btf), .armed_o(btf_armed)
  );

  sf_irq_out #(.STAT_W(STAT_W)) u_out (
    .flags_i(flags), .irq_en_i(irq_en_i), .status_o(status_o),
    .irq_o(irq_o), .scl_hold_o(scl_hold_o)
  );

  AST_MSL_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (periph_en_i && (ev_stop_i || ev_arb_lost_i) && !ev_start_req_i) |=> !status_o[MSL_POS])
    else $error("master flag kept"); // R3
  AST_ADSL_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_o[ADSL_POS] && stat_rd_i && !ev_addr_match_i) |=> !status_o[ADSL_POS])
    else $error("address flag kept"); // R4
  AST_RX_NOACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!status_o[BTF_POS] && ev_rx_done_i && !ack_en_i && !ev_tx_done_i && !ev_addr_ack_i)
    |=> !status_o[BTF_POS]) else $error("rx without ack set flag"); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> irq_en_i) else $error("irq without enable"); // R11
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_o[BTF_POS] && !btf_acc && periph_en_i) |=> scl_hold_o) else $error("hold dropped"); // R10
  AST_NO_ARM_UNUSED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(msl_armed || adsl_armed)) else $error("one-step arm"); // R9
  AST_ARMS_WITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sb_armed -> flags.sb) && (btf_armed -> flags.btf)) else $error("arm without flag"); // R9
endmodule

// File: tb/sim_i2c_stat_flags.sv
module sim_i2c_stat_flags;
  logic clk = 1'b0;
  logic rst_n;
  logic pe, ie, ack;
  logic sreq, sgen, stp, arb, am, aa, tx, rx, sr, dr, dw;
  logic [7:0] status;
  logic irq, hold;

  int n_chk = 0;
  int n_bad = 0;
  int m_sb, m_msl, m_adsl, m_btf, m_dir, a_sb, a_btf;

  always #4 clk = ~clk;

  i2c_stat_flags u0 (
    .clk(clk), .rst_n(rst_n), .periph_en_i(pe), .irq_en_i(ie), .ack_en_i(ack),
    .ev_start_req_i(sreq), .ev_start_gen_i(sgen), .ev_stop_i(stp), .ev_arb_lost_i(arb),
    .ev_addr_match_i(am), .ev_addr_ack_i(aa), .ev_tx_done_i(tx), .ev_rx_done_i(rx),
    .stat_rd_i(sr), .data_rd_i(dr), .data_wr_i(dw),
    .status_o(status), .irq_o(irq), .scl_hold_o(hold)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
  end

  task automatic idle();
    sreq = 0; sgen = 0; stp = 0; arb = 0; am = 0; aa = 0; tx = 0; rx = 0;
    sr = 0; dr = 0; dw = 0;
  endtask

  task automatic model_clear();
    m_sb = 0; m_msl = 0; m_adsl = 0; m_btf = 0; m_dir = 0; a_sb = 0; a_btf = 0;
  endtask

  task automatic model_step();
    int bset;
    if (!pe) begin
      model_clear();
      return;
    end
    if (sgen) begin m_sb = 1; a_sb = 0; end
    else if (m_sb == 1 && a_sb == 1 && dw) begin m_sb = 0; a_sb = 0; end
    else if (m_sb == 1 && sr) a_sb = 1;
    if (sreq) m_msl = 1;
    else if (stp || arb) m_msl = 0;
    if (am) m_adsl = 1;
    else if (sr) m_adsl = 0;
    bset = (tx || aa || (rx && ack)) ? 1 : 0;
    if (bset == 1) begin
      m_btf = 1; a_btf = 0; m_dir = (rx && ack) ? 1 : 0;
    end else if (m_btf == 1 && a_btf == 1 && ((m_dir == 1) ? dr : dw)) begin
      m_btf = 0; a_btf = 0;
    end else if (m_btf == 1 && sr) a_btf = 1;
  endtask

  task automatic compare();
    logic [7:0] es;
    logic ei, eh;
    es = {4'b0, m_btf[0], m_adsl[0], m_msl[0], m_sb[0]};
    ei = ie && (m_sb == 1 || m_adsl == 1 || m_btf == 1);
    eh = (m_adsl == 1 || m_btf == 1);
    n_chk++;
    if (status !== es || irq !== ei || hold !== eh) begin
      n_bad++;
      if (status[0] !== es[0]) $display("FAIL R2 sb actual=%b expected=%b", status[0], es[0]);
      if (status[1] !== es[1]) $display("FAIL R3 msl actual=%b expected=%b", status[1], es[1]);
      if (status[2] !== es[2]) $display("FAIL R4 adsl actual=%b expected=%b", status[2], es[2]);
      if (status[3] !== es[3]) $display("FAIL R5/R6 btf actual=%b expected=%b", status[3], es[3]);
      if (status[7:4] !== 4'b0) $display("FAIL R1 pad actual=%h expected=0", status[7:4]);
      if (irq !== ei) $display("FAIL R11 irq actual=%b expected=%b", irq, ei);
      if (hold !== eh) $display("FAIL R10 hold actual=%b expected=%b", hold, eh);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_st(string req, logic [7:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s status actual=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    idle(); pe = 0; ie = 1; ack = 1; rst_n = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc();
    expect_st("R1 reset", 8'h00);
    pe = 1; cyc();

    // R3 / R2 start sequence
    sreq = 1; cyc(); idle();
    expect_st("R3 master set", 8'h02);
    expect_bit("R11 msl no irq", irq, 1'b0);
    sgen = 1; cyc(); idle();
    expect_st("R2 start set", 8'h03);
    expect_bit("R11 irq on start", irq, 1'b1);
    dw = 1; cyc(); idle();
    expect_st("R2 write without read", 8'h03);
    sr = 1; dw = 1; cyc(); idle();
    expect_st("R12 same-cycle read", 8'h03);
    dw = 1; cyc(); idle();
    expect_st("R2 clear after read", 8'h02);

    // R9 read while clear arms nothing
    sr = 1; cyc(); idle();
    sgen = 1; cyc(); idle();
    dw = 1; cyc(); idle();
    expect_st("R9 early read no arm", 8'h03);

    // R8 set during clearing write
    sr = 1; cyc(); idle();
    dw = 1; sgen = 1; cyc(); idle();
    expect_st("R8 set wins", 8'h03);
    dw = 1; cyc(); idle();
    expect_st("R8 arm discarded", 8'h03);
    sr = 1; cyc(); idle();
    dw = 1; cyc(); idle();
    expect_st("R2 clear again", 8'h02);

    // R3 stop and arbitration loss
    stp = 1; cyc(); idle();
    expect_st("R3 stop clears", 8'h00);
    sreq = 1; cyc(); idle();
    arb = 1; cyc(); idle();
    expect_st("R3 arb clears", 8'h00);

    // R4 / R10 address match
    am = 1; cyc(); idle();
    expect_st("R4 addr set", 8'h04);
    expect_bit("R10 hold on addr", hold, 1'b1);
    sr = 1; cyc(); idle();
    expect_st("R4 read clears", 8'h00);
    expect_bit("R10 hold released", hold, 1'b0);

    // R5 transmitted byte
    tx = 1; cyc(); idle();
    expect_st("R5 tx set", 8'h08);
    sr = 1; cyc(); idle();
    dr = 1; cyc(); idle();
    expect_st("R5 read does not clear", 8'h08);
    dw = 1; cyc(); idle();
    expect_st("R5 write clears", 8'h00);
    aa = 1; cyc(); idle();
    expect_st("R5 addr ack set", 8'h08);
    sr = 1; cyc(); idle(); dw = 1; cyc(); idle();
    expect_st("R5 addr ack cleared", 8'h00);

    // R6 received byte
    ack = 0; rx = 1; cyc(); idle();
    expect_st("R6 no ack no set", 8'h00);
    ack = 1; rx = 1; cyc(); idle();
    expect_st("R6 rx set", 8'h08);
    sr = 1; cyc(); idle();
    dw = 1; cyc(); idle();
    expect_st("R6 write does not clear", 8'h08);
    dr = 1; cyc(); idle();
    expect_st("R6 read clears", 8'h00);

    // R11 enable gating
    am = 1; ie = 0; cyc(); idle();
    expect_bit("R11 irq masked", irq, 1'b0);
    ie = 1; cyc();
    expect_bit("R11 irq enabled", irq, 1'b1);

    // R7 disable
    sreq = 1; sgen = 1; tx = 1; cyc(); idle();
    expect_st("R7 before disable", 8'h0f);
    pe = 0; cyc();
    expect_st("R7 disable wipes", 8'h00);
    sgen = 1; am = 1; tx = 1; cyc(); idle();
    expect_st("R7 sets ignored", 8'h00);
    pe = 1; cyc();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      pe   = ($urandom_range(0, 99) != 0);
      ie   = ($urandom_range(0, 7) != 0);
      ack  = ($urandom_range(0, 3) != 0);
      sreq = ($urandom_range(0, 15) == 0);
      sgen = ($urandom_range(0, 15) == 0);
      stp  = ($urandom_range(0, 15) == 0);
      arb  = ($urandom_range(0, 31) == 0);
      am   = ($urandom_range(0, 15) == 0);
      aa   = ($urandom_range(0, 23) == 0);
      tx   = ($urandom_range(0, 15) == 0);
      rx   = ($urandom_range(0, 15) == 0);
      sr   = ($urandom_range(0, 3) == 0);
      dr   = ($urandom_range(0, 4) == 0);
      dw   = ($urandom_range(0, 4) == 0);
      cyc();
    end
    idle();
    summary();
  end
endmodule